// File: doc/BRIEF.md
# Iterative 64-by-32 Divider with Saturating Overflow

This block divides a 64-bit dividend by a 32-bit divisor over a fixed number of clock cycles. The dividend is assembled from two 32-bit words: the high word (the Y input) and the low word (operand A). The divisor is operand B. A select input picks signed or unsigned interpretation of both operands. The block returns a 32-bit quotient truncated toward zero. When the true quotient does not fit in 32 bits, the block saturates it and raises an overflow output. It also produces a four-bit condition-code word that reports the result. The remainder is discarded.

A request is issued by pulsing `start` while the block is idle. The operands are captured on that edge, and `busy` stays high while the shift-subtract engine runs. A one-cycle `done` pulse marks the moment the quotient, overflow bit and condition codes are updated. A zero divisor skips the engine entirely. In that case the block answers with `done` and `div_zero` on the cycle after the request and keeps its previous results.

Top module: `long_divider`

## Requirements
- R1: In unsigned mode (`signed_mode`=0) the dividend is `{y_hi, op_a}` with `y_hi` as the upper 32 bits, and a quotient that fits in 32 bits is returned exactly with `ovf`=0.
- R2: In unsigned mode, a true quotient above 0xFFFFFFFF yields `quotient`=0xFFFFFFFF and `ovf`=1.
- R3: In signed mode (`signed_mode`=1) both `{y_hi, op_a}` and `op_b` are two's complement. The quotient is truncated toward zero, and its sign is the XOR of the operand signs. A result in the range -2^31 to 2^31-1 is returned exactly with `ovf`=0.
- R4: In signed mode, a true quotient above 2^31-1 gives 0x7FFFFFFF and a true quotient below -2^31 gives 0x80000000, each with `ovf`=1. A quotient of exactly -2^31 does not overflow.
- R5: `flags` bit 3 is N (quotient bit 31), bit 2 is Z (quotient equals zero), bit 1 is V (equal to `ovf`) and bit 0 is C (always 0). All four bits are updated together with `quotient` at each completed division.
- R6: When `op_b` is zero at an accepted start, `done` and `div_zero` are both high in the following cycle and `busy` stays low. `quotient`, `ovf` and `flags` keep their previous values.
- R7: For a nonzero divisor, `busy` is high from the cycle after the accepting edge until `done`. `done` rises at rising edge 2*W+1 after the accepting edge (65 for W=32), lasts exactly one cycle, and is never high together with `busy`.
- R8: A `start` pulse while `busy` is high is ignored, including any operand values presented with it, and the running division completes with its original operands.
- R9: After reset, `busy`, `done`, `div_zero`, `ovf`, `quotient` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (accepted only when idle) |
| signed_mode | input | 1 | 1 = signed operands, 0 = unsigned |
| y_hi | input | 32 | Upper half of the dividend |
| op_a | input | 32 | Lower half of the dividend |
| op_b | input | 32 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero, pulses with `done` |
| quotient | output | 32 | Saturated quotient |
| ovf | output | 1 | Quotient did not fit and was saturated |
| flags | output | 4 | Condition codes {N, Z, V, C} |

## Verification
The directed tests aim at the overflow boundaries: an unsigned quotient of exactly 0xFFFFFFFF against 2^32, a signed quotient of exactly -2^31 against 2^31 and -2^31-1, and the most negative dividend divided by -1. A design that compares the magnitude against the wrong limit, or that ignores the quotient sign, would flag overflow on a legal -2^31 result or saturate to the wrong end. Other tests check that a negative dividend yielding a zero quotient gives Z=1 and N=0, and that a division by zero leaves the old quotient and flags in place; a design that writes the result registers on that path fails the latter. A `start` pulse with different operands in the middle of a run checks that the captured operands are not overwritten.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/div_rst_sync.sv
module div_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0]   y_hi,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic           signed_mode,
  output logic [2*W-1:0] dvd_mag,
  output logic [W-1:0]   dvs_mag,
  output logic           q_neg,
  output logic           b_zero
);

  logic [2*W-1:0] dvd_raw;
  logic           dvd_neg;
  logic           dvs_neg;

  always_comb begin
    dvd_raw = {y_hi, op_a};
    dvd_neg = signed_mode & y_hi[W-1];
    dvs_neg = signed_mode & op_b[W-1];
    dvd_mag = dvd_neg ? (~dvd_raw + 1'b1) : dvd_raw;
    dvs_mag = dvs_neg ? (~op_b + 1'b1) : op_b;
    q_neg   = dvd_neg ^ dvs_neg;
    b_zero  = (op_b == '0);
  end

endmodule

// File: rtl/div_shift_core.sv
module div_shift_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [2*W-1:0] dvd_in,
  input  logic [W-1:0]   dvs_in,
  output logic [2*W-1:0] quo_mag
);

  logic [W-1:0]   rem_q, rem_d;
  logic [2*W-1:0] sh_q, sh_d;
  logic [W-1:0]   dvs_q, dvs_d;
  logic [W:0]     trial;
  logic [W+1:0]   diff;
  logic           qbit;
  logic           en;

  always_comb begin
    trial = {rem_q, sh_q[2*W-1]};
    diff  = {1'b0, trial} - {2'b00, dvs_q};
    qbit  = ~diff[W+1];
    en    = load | step;
    if (load) begin
      rem_d = '0;
      sh_d  = dvd_in;
      dvs_d = dvs_in;
    end else begin
      rem_d = qbit ? diff[W-1:0] : trial[W-1:0];
      sh_d  = {sh_q[2*W-2:0], qbit};
      dvs_d = dvs_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      sh_q  <= '0;
      dvs_q <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      sh_q  <= sh_d;
      dvs_q <= dvs_d;
    end
  end

  assign quo_mag = sh_q;

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
  import ldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] quo_mag,
  input  logic           q_neg,
  input  logic           signed_mode,
  output logic [W-1:0]   q_out,
  output logic           ovf_out,
  output cc_t            cc_out
);

  logic [W-1:0] low;
  logic         hi_nz;
  logic         low_rest_nz;

  always_comb begin
    low         = quo_mag[W-1:0];
    hi_nz       = |quo_mag[2*W-1:W];
    low_rest_nz = |low[W-2:0];
    if (!signed_mode) begin
      ovf_out = hi_nz;
      q_out   = hi_nz ? '1 : low;
    end else if (!q_neg) begin
      ovf_out = hi_nz | low[W-1];
      q_out   = ovf_out ? {1'b0, {(W-1){1'b1}}} : low;
    end else begin
      ovf_out = hi_nz | (low[W-1] & low_rest_nz);
      q_out   = ovf_out ? {1'b1, {(W-1){1'b0}}} : (~low + 1'b1);
    end
    cc_out.n = q_out[W-1];
    cc_out.z = (q_out == '0);
    cc_out.v = ovf_out;
    cc_out.c = 1'b0;
  end

endmodule

// File: rtl/long_divider.sv
module long_divider
  import ldiv_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] y_hi,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic         div_zero,
  output logic [W-1:0] quotient,
  output logic         ovf,
  output logic [3:0]   flags
);

  localparam int ITER = 2 * W;
  localparam int CW   = $clog2(ITER + 1);

  logic           rst_sync_n;
  div_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           mode_q, neg_q;
  logic [2*W-1:0] dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           q_neg;
  logic           b_zero;
  logic [2*W-1:0] quo_mag;
  logic [W-1:0]   q_fix;
  logic           ovf_fix;
  cc_t            cc_fix;
  cc_t            cc_q;
  logic [W-1:0]   q_q;
  logic           ovf_q, done_q, dz_q;
  logic           accept, go, dz_hit, run_step, fin;

  div_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  div_operand_prep #(.W(W)) u_prep (
    .y_hi        (y_hi),
    .op_a        (op_a),
    .op_b        (op_b),
    .signed_mode (signed_mode),
    .dvd_mag     (dvd_mag),
    .dvs_mag     (dvs_mag),
    .q_neg       (q_neg),
    .b_zero      (b_zero)
  );

  div_shift_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (go),
    .step    (run_step),
    .dvd_in  (dvd_mag),
    .dvs_in  (dvs_mag),
    .quo_mag (quo_mag)
  );

  div_result_fix #(.W(W)) u_fix (
    .quo_mag     (quo_mag),
    .q_neg       (neg_q),
    .signed_mode (mode_q),
    .q_out       (q_fix),
    .ovf_out     (ovf_fix),
    .cc_out      (cc_fix)
  );

  // control decode and next state
  always_comb begin
    accept   = start & (state_q == ST_IDLE);
    go       = accept & ~b_zero;
    dz_hit   = accept & b_zero;
    run_step = (state_q == ST_RUN);
    fin      = (state_q == ST_FIN);
    state_d  = state_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_RUN;
          cnt_d   = CW'(ITER);
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) state_d = ST_FIN;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      dz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= dz_hit | fin;
      dz_q    <= dz_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= 1'b0;
      neg_q  <= 1'b0;
    end else if (go) begin
      mode_q <= signed_mode;
      neg_q  <= q_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q_q   <= '0;
      ovf_q <= 1'b0;
      cc_q  <= '0;
    end else if (fin) begin
      q_q   <= q_fix;
      ovf_q <= ovf_fix;
      cc_q  <= cc_fix;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign div_zero = dz_q;
  assign quotient = q_q;
  assign ovf      = ovf_q;
  assign flags    = {cc_q.n, cc_q.z, cc_q.v, cc_q.c};

endmodule

// File: rtl/long_divider_chk.sv
module long_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         div_zero,
  input logic [W-1:0] quotient,
  input logic         ovf,
  input logic [3:0]   flags,
  input logic         mode
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));

  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_dz_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (done && !busy));

  assert_dz_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> ((flags == $past(flags)) && (quotient == $past(quotient))));

  assert_usat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && ovf && !mode) |-> (quotient == {W{1'b1}}));

  assert_ssat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && ovf && mode) |->
      ((quotient == {1'b0, {(W-1){1'b1}}}) || (quotient == {1'b1, {(W-1){1'b0}}})));

  assert_carry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[0] == 1'b0);

  assert_v_is_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flags[1] == ovf);

endmodule

bind long_divider long_divider_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .div_zero (div_zero),
  .quotient (quotient),
  .ovf      (ovf),
  .flags    (flags),
  .mode     (mode_q)
);

// File: tb/long_divider_test.sv
`timescale 1ns/1ps
module long_divider_test;

  localparam int W       = 32;
  localparam int LAT     = 2 * W + 2;
  localparam int WD_LIMIT = 100000;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          signed_mode;
  logic [W-1:0]  y_hi, op_a, op_b;
  logic          busy, done, div_zero, ovf;
  logic [W-1:0]  quotient;
  logic [3:0]    flags;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  long_divider #(.W(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .y_hi        (y_hi),
    .op_a        (op_a),
    .op_b        (op_b),
    .busy        (busy),
    .done        (done),
    .div_zero    (div_zero),
    .quotient    (quotient),
    .ovf         (ovf),
    .flags       (flags)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] y, input logic [31:0] a,
                                input logic [31:0] b, input logic s,
                                output logic [31:0] q, output logic v);
    logic [63:0] d, dm, bm, qm;
    logic        neg;
    d = {y, a};
    if (!s) begin
      qm = d / {32'b0, b};
      v  = (qm > 64'h0000_0000_FFFF_FFFF);
      q  = v ? 32'hFFFF_FFFF : qm[31:0];
    end else begin
      dm  = d[63] ? (64'd0 - d) : d;
      bm  = b[31] ? {32'b0, 32'd0 - b} : {32'b0, b};
      qm  = dm / bm;
      neg = d[63] ^ b[31];
      if (!neg) begin
        v = (qm > 64'h0000_0000_7FFF_FFFF);
        q = v ? 32'h7FFF_FFFF : qm[31:0];
      end else begin
        v = (qm > 64'h0000_0000_8000_0000);
        q = v ? 32'h8000_0000 : (32'd0 - qm[31:0]);
      end
    end
  endfunction

  // issue one request, return number of falling edges until done
  task automatic issue(input logic [31:0] y, input logic [31:0] a,
                       input logic [31:0] b, input logic s, output int lat);
    @(negedge clk);
    y_hi = y; op_a = a; op_b = b; signed_mode = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(input string req, input logic [31:0] y, input logic [31:0] a,
                          input logic [31:0] b, input logic s);
    int lat;
    logic [31:0] eq;
    logic        ev;
    model(y, a, b, s, eq, ev);
    issue(y, a, b, s, lat);
    chk("R7", "latency", 64'(lat), 64'(LAT));
    chk(req, "quotient", 64'(quotient), 64'(eq));
    chk(req, "ovf", 64'(ovf), 64'(ev));
    chk("R5", "flags", 64'(flags), 64'({eq[31], eq == 32'd0, ev, 1'b0}));
    chk("R6", "div_zero low", 64'(div_zero), 64'd0);
    @(negedge clk);
    chk("R7", "done single", 64'(done), 64'd0);
  endtask

  task automatic test_reset;
    chk("R9", "busy", 64'(busy), 64'd0);
    chk("R9", "done", 64'(done), 64'd0);
    chk("R9", "div_zero", 64'(div_zero), 64'd0);
    chk("R9", "ovf", 64'(ovf), 64'd0);
    chk("R9", "quotient", 64'(quotient), 64'd0);
    chk("R9", "flags", 64'(flags), 64'd0);
  endtask

  task automatic test_unsigned;
    run_case("R1", 32'h0, 32'd100, 32'd7, 1'b0);
    run_case("R1", 32'h0000_0001, 32'h0000_0000, 32'h0000_0010, 1'b0);
    run_case("R1", 32'h0000_0001, 32'hFFFF_FFFF, 32'd2, 1'b0);
    run_case("R1", 32'h0, 32'hFFFF_FFFF, 32'd1, 1'b0);
    run_case("R1", 32'h0, 32'd3, 32'd9, 1'b0);
  endtask

  task automatic test_unsigned_ovf;
    run_case("R2", 32'h0000_0001, 32'h0, 32'd1, 1'b0);
    run_case("R2", 32'h0000_0005, 32'h1234_5678, 32'd5, 1'b0);
    run_case("R2", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, 1'b0);
  endtask

  task automatic test_signed;
    run_case("R3", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1'b1);
    run_case("R3", 32'h0, 32'd7, 32'hFFFF_FFFE, 1'b1);
    run_case("R3", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1'b1);
    run_case("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 1'b1);
    run_case("R4", 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1'b1);
    run_case("R3", 32'h0, 32'h7FFF_FFFF, 32'd1, 1'b1);
  endtask

  task automatic test_signed_ovf;
    run_case("R4", 32'h0, 32'h8000_0000, 32'd1, 1'b1);
    run_case("R4", 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run_case("R4", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1'b1);
    run_case("R4", 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 1'b1);
    run_case("R4", 32'h0000_0003, 32'h0, 32'hFFFF_FFFD, 1'b1);
  endtask

  task automatic test_div_zero;
    int lat;
    logic [31:0] q0;
    logic [3:0]  f0;
    logic        v0;
    run_case("R1", 32'h0, 32'd100, 32'd7, 1'b0);
    q0 = quotient; f0 = flags; v0 = ovf;
    issue(32'h0000_0001, 32'd55, 32'd0, 1'b1, lat);
    chk("R6", "dz latency", 64'(lat), 64'd1);
    chk("R6", "div_zero", 64'(div_zero), 64'd1);
    chk("R6", "busy low", 64'(busy), 64'd0);
    chk("R6", "quotient kept", 64'(quotient), 64'(q0));
    chk("R6", "flags kept", 64'(flags), 64'(f0));
    chk("R6", "ovf kept", 64'(ovf), 64'(v0));
    @(negedge clk);
    chk("R6", "div_zero pulse", 64'(div_zero), 64'd0);
    chk("R6", "done pulse", 64'(done), 64'd0);
  endtask

  task automatic test_start_while_busy;
    int n;
    @(negedge clk);
    y_hi = 32'h0; op_a = 32'd1000; op_b = 32'd7; signed_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "busy after start", 64'(busy), 64'd1);
    n = 1;
    while (n < 10) begin
      @(negedge clk);
      n++;
    end
    y_hi = 32'h0000_0009; op_a = 32'd1; op_b = 32'd3; signed_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    n++;
    start = 1'b0;
    chk("R8", "still busy", 64'(busy), 64'd1);
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R8", "latency unchanged", 64'(n), 64'(LAT));
    chk("R8", "quotient of first request", 64'(quotient), 64'd142);
    chk("R8", "ovf of first request", 64'(ovf), 64'd0);
    @(negedge clk);
    chk("R8", "no second run", 64'(busy), 64'd0);
  endtask

  initial begin
    #(WD_LIMIT * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual=no completion expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; signed_mode = 1'b0;
    y_hi = '0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_unsigned();
    test_unsigned_ovf();
    test_signed();
    test_signed_ovf();
    test_div_zero();
    test_start_while_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule